// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Controller

This block collects 32 interrupt sources from a peripheral subsystem and presents them to the processor as one interrupt line. It also reports the index of the pending source that should be serviced first. Software reaches two registers over a simple register bus. The enable register selects which sources may interrupt. The status register shows which sources are currently asserting.

Most status bits are not stored. Each of them follows the level of its source input after a two-flop synchroniser. Bits 10 and 11 are different: they capture events. A rising edge on either of those sources sets the bit, and the bit holds until software writes a one to it. Writes to every other status bit are dropped. Because of this, writing all ones to the status register is a safe way to clear both event bits.

The pending set is the bitwise AND of status and enable. A registered stage turns it into the interrupt line, a valid flag and a 5-bit index. The lowest-numbered pending source has the highest priority.

Top module: `periph_irq_agg`

## Requirements
- R1: After reset the enable register reads 0, both event bits read 0, and `irq_o`, `irq_valid_o` and `irq_idx_o` are all 0.
- R2: The enable register sits at byte address 0x0 and can be read and written in full. In the cycle after a write, a read there returns the value just written.
- R3: The status register sits at byte address 0x4. Every bit other than 10 and 11 reads as its source level, two clock edges after that source changes.
- R4: Status bits 10 and 11 set on a rising edge of their source. The bit is visible two edges after the rise and stays set after the source falls.
- R5: Writing a one to status bit 10 or 11 clears that bit. Writing a zero leaves it unchanged. Writes to any other status bit have no effect.
- R6: If a rising edge on an event source and a clearing write to the same bit fall on the same clock edge, the bit ends up set.
- R7: `irq_o` is the OR of (status AND enable). It is registered and changes one edge after the status or enable change that causes it.
- R8: When several sources are pending, `irq_idx_o` gives the lowest pending bit index, from 0 to 31, with the same one-edge latency.
- R9: When nothing is pending, `irq_o` and `irq_valid_o` are 0 and `irq_idx_o` is 0.
- R10: Any address other than 0x0 and 0x4 reads as zero, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_i | input | 32 | Interrupt source levels, asynchronous |
| irq_o | output | 1 | Aggregated interrupt to the processor |
| irq_valid_o | output | 1 | High when `irq_idx_o` names a pending source |
| irq_idx_o | output | 5 | Index of the lowest pending source |

## Verification
The results arrive at different times:
- A source change is visible in status after two clock edges, and in the interrupt outputs after three.
- An enable write or an event clear reaches the read port at once and the interrupt outputs one edge later.

The bench drives every stimulus on a falling edge and counts falling edges up to the edge where each result is due. At a boundary it samples both the cycle before and the cycle of the change, so that a wrong latency shows up in either direction. The set-wins case places the clearing write exactly on the edge where the synchronised rising edge is latched.

// File: rtl/periph_irq_agg.sv
module periph_irq_agg #(
  parameter int              NSRC     = 32,
  parameter int              AW       = 3,
  parameter logic [NSRC-1:0] EVT_BITS = 32'h0000_0C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o,
  output logic              irq_valid_o,
  output logic [$clog2(NSRC)-1:0] irq_idx_o
);
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [AW-1:0] EN_ADDR = AW'(0);
  localparam logic [AW-1:0] ST_ADDR = AW'(4);

  logic [NSRC-1:0] sync1, sync2, en_q, evt_q, status, pending, rise, clr;
  logic [IDX_W-1:0] first_idx;
  logic wr_en, wr_st;

  assign wr_en   = bus_we && (bus_addr == EN_ADDR);
  assign wr_st   = bus_we && (bus_addr == ST_ADDR);
  assign rise    = sync1 & ~sync2 & EVT_BITS;
  assign clr     = wr_st ? (bus_wdata & EVT_BITS) : '0;
  assign status  = (sync2 & ~EVT_BITS) | (evt_q & EVT_BITS);
  assign pending = status & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      en_q  <= '0;
      evt_q <= '0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
      if (wr_en) en_q <= bus_wdata;
      evt_q <= (evt_q & ~clr) | rise;
    end
  end

  always_comb begin
    first_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pending[i]) first_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      irq_valid_o <= 1'b0;
      irq_idx_o   <= '0;
    end else begin
      irq_o       <= |pending;
      irq_valid_o <= |pending;
      irq_idx_o   <= first_idx;
    end
  end

  always_comb begin
    case (bus_addr)
      EN_ADDR: bus_rdata = en_q;
      ST_ADDR: bus_rdata = status;
      default: bus_rdata = '0;
    endcase
  end

  AST_EN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> en_q == $past(bus_wdata)); // R2
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_q[10]) && !($past(wr_st) && $past(bus_wdata[10]))) |-> evt_q[10]); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise[11]) |-> evt_q[11]); // R6
  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) == '0) |-> !irq_o); // R7
  AST_IDX_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> ((($past(pending) >> irq_idx_o) & 1) == 1 &&
                     ($past(pending) & ((NSRC'(1) << irq_idx_o) - 1)) == '0)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid_o |-> (irq_idx_o == '0 && !irq_o)); // R9
endmodule

// File: tb/periph_irq_agg_tb.sv
`timescale 1ns/1ps
module periph_irq_agg_tb;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, src_i = 0;
  logic        irq_o, irq_valid_o;
  logic [4:0]  irq_idx_o;
  int tests_run = 0, tests_failed = 0;

  always #2.5 clk = ~clk;

  periph_irq_agg u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i), .irq_o(irq_o),
    .irq_valid_o(irq_valid_o), .irq_idx_o(irq_idx_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic chk_out(string req, logic irq, logic [4:0] idx);
    chk({req, " irq"}, {31'd0, irq_o}, {31'd0, irq});
    chk({req, " valid"}, {31'd0, irq_valid_o}, {31'd0, irq});
    chk({req, " idx"}, {27'd0, irq_idx_o}, {27'd0, idx});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'h0, d); chk("R1 enable", d, 0);
    rd(3'h4, d); chk("R1 status", d, 0);
    chk_out("R1", 0, 0);
  endtask

  task automatic t_enable_rw;
    logic [31:0] d;
    wr(3'h0, 32'hA5A5_5A5A); rd(3'h0, d); chk("R2 readback", d, 32'hA5A5_5A5A);
    wr(3'h0, 32'h0); rd(3'h0, d); chk("R2 readback zero", d, 0);
  endtask

  task automatic t_live;
    logic [31:0] d;
    @(negedge clk); src_i = 32'h0000_0008;
    wait_n(1); rd(3'h4, d); chk("R3 not yet", d, 0);
    wait_n(1); rd(3'h4, d); chk("R3 level high", d, 32'h8);
    src_i = 32'h0000_0020; wait_n(2); rd(3'h4, d); chk("R3 level moves", d, 32'h20);
    wr(3'h4, 32'hFFFF_FFFF); rd(3'h4, d); chk("R5 live bit ignores write", d, 32'h20);
    src_i = 0; wait_n(2); rd(3'h4, d); chk("R3 level low", d, 0);
  endtask

  task automatic t_event;
    logic [31:0] d;
    @(negedge clk); src_i = 32'h400;
    @(negedge clk); src_i = 0;
    wait_n(1); rd(3'h4, d); chk("R4 event set", d, 32'h400);
    wait_n(4); rd(3'h4, d); chk("R4 event held", d, 32'h400);
    wr(3'h4, 32'h0); rd(3'h4, d); chk("R5 zero write keeps", d, 32'h400);
    wr(3'h4, 32'h800); rd(3'h4, d); chk("R5 other bit keeps", d, 32'h400);
    wr(3'h4, 32'h400); rd(3'h4, d); chk("R5 cleared", d, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk); src_i = 32'h800;
    wait_n(3); src_i = 0; wait_n(2);
    rd(3'h4, d); chk("R6 primed", d, 32'h800);
    @(negedge clk); src_i = 32'h800;
    @(negedge clk); bus_addr = 3'h4; bus_wdata = 32'h800; bus_we = 1;
    @(negedge clk); bus_we = 0;
    rd(3'h4, d); chk("R6 set beats clear", d, 32'h800);
    src_i = 0; wr(3'h4, 32'hFFFF_FFFF); wait_n(2);
    rd(3'h4, d); chk("R6 cleanup", d, 0);
  endtask

  task automatic t_pending;
    wr(3'h0, (32'd1 << 7) | (32'd1 << 20) | (32'd1 << 31));
    @(negedge clk); src_i = 32'd1 << 20;
    wait_n(2); chk_out("R7 before", 0, 0);
    wait_n(1); chk_out("R7 after", 1, 20);
    src_i = src_i | (32'd1 << 7) | (32'd1 << 31);
    wait_n(3); chk_out("R8 lowest wins", 1, 7);
    wr(3'h0, (32'd1 << 20) | (32'd1 << 31));
    chk_out("R7 mask not yet", 1, 7);
    wait_n(1); chk_out("R8 next lowest", 1, 20);
    wr(3'h0, 32'd1 << 31); wait_n(1); chk_out("R8 top bit", 1, 31);
    wr(3'h0, 32'h0); wait_n(1); chk_out("R9 masked", 0, 0);
    wr(3'h0, 32'h0000_0001); wait_n(1); chk_out("R9 enable without source", 0, 0);
    src_i = 0; wr(3'h0, 32'h0);
  endtask

  task automatic t_bad_addr;
    logic [31:0] d;
    wr(3'h0, 32'h1234_5678);
    wr(3'h2, 32'hFFFF_FFFF); rd(3'h0, d); chk("R10 enable untouched", d, 32'h1234_5678);
    rd(3'h2, d); chk("R10 reads zero", d, 0);
    rd(3'h6, d); chk("R10 reads zero high", d, 0);
    wr(3'h0, 32'h0);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    tests_run++; tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    wait_n(3); rst_n = 1; wait_n(2);
    t_reset();
    t_enable_rw();
    t_live();
    t_event();
    t_set_wins();
    t_pending();
    t_bad_addr();
    report();
  end
endmodule